// File: doc/BRIEF.md
# Vectored Two-Level Interrupt Controller

This block arbitrates the interrupt requests of a small 8-bit microcontroller core. Five sources raise one-cycle event pulses: external 0, timer 0 overflow, external 1, timer 1 overflow and a serial-port event. A sixth source, timer 2, can be enabled through a parameter. Each pulse sets a pending flag. A flag becomes a candidate when its own enable bit and the global enable bit are both set.

The controller picks one winner. A high-priority candidate beats any low-priority one. Within one level the lowest source index wins. The controller drives a request line and the 16-bit vector address of the winner to the CPU.

When the CPU accepts the request it strobes `ack_i`. This pushes the in-service level of the winner. A return strobe `reti_i` pops the most important active level. The pushing of the program counter, the stack and instruction decode are outside the block; they are represented only by these strobes.

Top module: `intc_top`

## Requirements
- R1: A pending source can raise `irq_o` only if its own enable bit is set. Enable bit i belongs to source i: 0 ext0, 1 tmr0, 2 ext1, 3 tmr1, 4 serial, 5 tmr2.
- R2: While `irq_o` is high, `vec_o` equals 16'h0003 + 8*index of the winner (ext0 0003h, tmr0 000Bh, ext1 0013h, tmr1 001Bh, serial 0023h, tmr2 002Bh). `vec_o` is 0 while `irq_o` is low.
- R3: Enable bit 7 is a global gate. While it is clear, `irq_o` stays low whatever else is set.
- R4: Priority bit i set makes source i high priority. Any high candidate beats every low one. Within a level, the lowest index wins.
- R5: `ack_i` high while `irq_o` is high sets the in-service bit of the winner's level on the next cycle: `act_o[1]` for high, `act_o[0]` for low.
- R6: While `act_o[1]` is set, `irq_o` stays low.
- R7: While only `act_o[0]` is set, only a high-priority candidate raises `irq_o`.
- R8: `reti_i` clears `act_o[1]` if it is set, otherwise `act_o[0]`.
- R9: Accepting a source clears its pending flag, except for the serial flag (index 4), which stays set.
- R10: An event pulse sets the pending flag on the next cycle. It wins over a clear in the same cycle.
- R11: A `sw_clr_i` bit clears the matching pending flag on the next cycle.
- R12: After reset the enable, priority, pending and in-service state are all zero, `irq_o` is low and `vec_o` is 0.
- R13: Enable and priority bits with no source behind them read as 0. With five sources, writing FFh gives 9Fh and 1Fh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_SRC | Event pulses that set the pending flags |
| sw_clr_i | input | NUM_SRC | Software clear of the pending flags |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 8 | Enable register write data |
| pri_we_i | input | 1 | Priority register write strobe |
| pri_wdata_i | input | 8 | Priority register write data |
| ack_i | input | 1 | CPU accepts the current request |
| reti_i | input | 1 | Return from interrupt |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 16 | Vector address of the winner |
| en_o | output | 8 | Enable register |
| pri_o | output | 8 | Priority register |
| pend_o | output | NUM_SRC | Pending flags |
| act_o | output | 2 | In-service levels: bit 1 high, bit 0 low |

## Verification
The bench builds the block with its defaults: five sources, and every source except serial cleared on acceptance. With five sources there are 32 enable masks, 32 priority masks and 32 pending patterns. The bench sweeps all 32768 combinations with the global gate on, and all enable and pending patterns with the gate off. For each one it computes the expected winner arithmetically. Directed sequences then walk through nesting, blocking, returns, the flag-clear rules and set-versus-clear collisions.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int VEC_W   = 16;
  localparam int GE_BIT  = 7;
  localparam int MAX_SRC = 6;

  typedef struct packed {
    logic hi;
    logic lo;
  } lvl_t;

  function automatic logic [VEC_W-1:0] vec_of(logic [2:0] idx);
    return 16'h0003 + {10'd0, idx, 3'd0};
  endfunction
endpackage

// File: rtl/intc_pend.sv
module intc_pend #(
  parameter int NUM_SRC = 5,
  parameter logic [7:0] AUTO_CLR_MASK = 8'hEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SRC-1:0] sw_clr_i,
  input  logic               take_i,
  input  logic [NUM_SRC-1:0] take_oh_i,
  output logic [NUM_SRC-1:0] pend_o
);
  localparam logic [NUM_SRC-1:0] AUTO = AUTO_CLR_MASK[NUM_SRC-1:0];

  logic [NUM_SRC-1:0] pend_q, clr;

  assign clr = sw_clr_i | ({NUM_SRC{take_i}} & take_oh_i & AUTO);

  // a fresh event wins over any clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr) | evt_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/intc_pick.sv
module intc_pick #(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [N-1:0]  oh_o,
  output logic [IW-1:0] idx_o
);
  // descending scan: the last hit, i.e. the lowest index, is kept
  always_comb begin
    any_o = 1'b0;
    oh_o  = '0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o    = 1'b1;
        oh_o     = '0;
        oh_o[i]  = 1'b1;
        idx_o    = IW'(i);
      end
    end
  end
endmodule

// File: rtl/intc_arb.sv
module intc_arb #(
  parameter int NUM_SRC = 5,
  parameter int IW      = 3
) (
  input  logic [NUM_SRC-1:0] cand_i,
  input  logic [NUM_SRC-1:0] pri_i,
  input  logic [1:0]         allow_i,
  output logic               req_o,
  output logic               gnt_hi_o,
  output logic [NUM_SRC-1:0] gnt_oh_o,
  output logic [IW-1:0]      gnt_idx_o
);
  logic [1:0]         any;
  logic [NUM_SRC-1:0] oh  [2];
  logic [IW-1:0]      idx [2];

  for (genvar l = 0; l < 2; l++) begin : g_lvl
    logic [NUM_SRC-1:0] lvl_req;
    assign lvl_req = cand_i & (l == 1 ? pri_i : ~pri_i) & {NUM_SRC{allow_i[l]}};
    intc_pick #(.N(NUM_SRC), .IW(IW)) u_pick (
      .req_i (lvl_req),
      .any_o (any[l]),
      .oh_o  (oh[l]),
      .idx_o (idx[l])
    );
  end

  assign req_o     = |any;
  assign gnt_hi_o  = any[1];
  assign gnt_oh_o  = any[1] ? oh[1]  : oh[0];
  assign gnt_idx_o = any[1] ? idx[1] : idx[0];
endmodule

// File: rtl/intc_level.sv
module intc_level
  import intc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic take_hi_i,
  input  logic reti_i,
  output lvl_t act_o
);
  lvl_t act_q, act_n;

  // pop first, then push: a pre-empting take in the same cycle survives
  always_comb begin
    act_n = act_q;
    if (reti_i) begin
      if (act_q.hi) act_n.hi = 1'b0;
      else          act_n.lo = 1'b0;
    end
    if (take_i) begin
      if (take_hi_i) act_n.hi = 1'b1;
      else           act_n.lo = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= '0;
    else         act_q <= act_n;
  end

  assign act_o = act_q;
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 5,
  parameter logic [7:0] AUTO_CLR_MASK = 8'hEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SRC-1:0] sw_clr_i,
  input  logic               en_we_i,
  input  logic [7:0]         en_wdata_i,
  input  logic               pri_we_i,
  input  logic [7:0]         pri_wdata_i,
  input  logic               ack_i,
  input  logic               reti_i,
  output logic               irq_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic [7:0]         en_o,
  output logic [7:0]         pri_o,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [1:0]         act_o
);
  localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [7:0] SRC_MASK = 8'((1 << NUM_SRC) - 1);
  localparam logic [7:0] EN_MASK  = SRC_MASK | (8'h1 << GE_BIT);

  logic [7:0]         en_q, pri_q;
  logic [NUM_SRC-1:0] pend, cand, gnt_oh;
  logic [IW-1:0]      gnt_idx;
  logic               req, gnt_hi, take;
  logic [1:0]         allow;
  lvl_t               act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      pri_q <= '0;
    end else begin
      if (en_we_i)  en_q  <= en_wdata_i & EN_MASK;
      if (pri_we_i) pri_q <= pri_wdata_i & SRC_MASK;
    end
  end

  assign cand     = pend & en_q[NUM_SRC-1:0] & {NUM_SRC{en_q[GE_BIT]}};
  assign allow[1] = !act.hi;
  assign allow[0] = !act.hi && !act.lo;
  assign take     = ack_i && req;

  intc_pend #(.NUM_SRC(NUM_SRC), .AUTO_CLR_MASK(AUTO_CLR_MASK)) u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt_i),
    .sw_clr_i  (sw_clr_i),
    .take_i    (take),
    .take_oh_i (gnt_oh),
    .pend_o    (pend)
  );

  intc_arb #(.NUM_SRC(NUM_SRC), .IW(IW)) u_arb (
    .cand_i    (cand),
    .pri_i     (pri_q[NUM_SRC-1:0]),
    .allow_i   (allow),
    .req_o     (req),
    .gnt_hi_o  (gnt_hi),
    .gnt_oh_o  (gnt_oh),
    .gnt_idx_o (gnt_idx)
  );

  intc_level u_level (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_i    (take),
    .take_hi_i (gnt_hi),
    .reti_i    (reti_i),
    .act_o     (act)
  );

  assign irq_o  = req;
  assign vec_o  = req ? vec_of(3'(gnt_idx)) : '0;
  assign en_o   = en_q;
  assign pri_o  = pri_q;
  assign pend_o = pend;
  assign act_o  = {act.hi, act.lo};
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int NUM_SRC = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ack_i,
  input logic               reti_i,
  input logic               irq_o,
  input logic [15:0]        vec_o,
  input logic [7:0]         en_o,
  input logic [7:0]         pri_o,
  input logic [NUM_SRC-1:0] pend_o,
  input logic [1:0]         act_o
);
  assert_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> en_o[7]);

  assert_src_en_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> en_o[vec_o[5:3]]);

  assert_vec_form_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (vec_o[2:0] == 3'd3 && vec_o[15:6] == '0));

  assert_hi_blocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_o[1] |-> !irq_o);

  assert_preempt_hi_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && act_o[0]) |-> pri_o[vec_o[5:3]]);

  assert_take_hi_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && pri_o[vec_o[5:3]]) |=> act_o[1]);

  assert_reti_hi_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && act_o[1]) |=> !act_o[1]);

  assert_reti_lo_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && act_o == 2'b01 && !(ack_i && irq_o)) |=> act_o == 2'b00);
endmodule

bind intc_top intc_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .ack_i  (ack_i),
  .reti_i (reti_i),
  .irq_o  (irq_o),
  .vec_o  (vec_o),
  .en_o   (en_o),
  .pri_o  (pri_o),
  .pend_o (pend_o),
  .act_o  (act_o)
);

// File: tb/tb_intc_top.sv
module tb_intc_top;
  localparam int N = 5;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] evt_i = '0, sw_clr_i = '0;
  logic         en_we_i = 1'b0, pri_we_i = 1'b0, ack_i = 1'b0, reti_i = 1'b0;
  logic [7:0]   en_wdata_i = '0, pri_wdata_i = '0;
  logic         irq_o;
  logic [15:0]  vec_o;
  logic [7:0]   en_o, pri_o;
  logic [N-1:0] pend_o;
  logic [1:0]   act_o;

  int n_chk = 0, n_fail = 0;

  always #2 clk_i = ~clk_i;

  intc_top #(.NUM_SRC(N)) dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // arithmetic model: 0 means no request
  function automatic logic [15:0] exp_vec(logic [7:0] en, logic [7:0] pri, logic [N-1:0] pend, bit hi_only);
    logic [N-1:0] c = pend & en[N-1:0] & {N{en[7]}};
    for (int i = 0; i < N; i++) if (c[i] && pri[i]) return 16'(3 + 8 * i);
    if (hi_only) return 16'h0;
    for (int i = 0; i < N; i++) if (c[i]) return 16'(3 + 8 * i);
    return 16'h0;
  endfunction

  task automatic tick();
    @(negedge clk_i);
    evt_i = '0; sw_clr_i = '0; en_we_i = 0; pri_we_i = 0; ack_i = 0; reti_i = 0;
  endtask

  task automatic chk_req(input string req, input logic [15:0] ev);
    chk({irq_o, vec_o} == {ev != 0, ev}, req, {irq_o, vec_o}, {ev != 0, ev});
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R12
    chk({irq_o, vec_o, en_o, pri_o, pend_o, act_o} == '0, "R12", {irq_o, vec_o}, 0);
    chk({en_o, pri_o, pend_o, act_o} == '0, "R12", {en_o, pri_o}, 0);

    // R13
    en_we_i = 1; en_wdata_i = 8'hFF; pri_we_i = 1; pri_wdata_i = 8'hFF;
    tick();
    chk({en_o, pri_o} == 16'h9F1F, "R13", {en_o, pri_o}, 16'h9F1F);

    // full sweep, gate on: R1 R2 R4
    for (int e = 0; e < 32; e++)
      for (int p = 0; p < 32; p++)
        for (int q = 0; q < 32; q++) begin
          en_we_i = 1; en_wdata_i = 8'h80 | 8'(e);
          pri_we_i = 1; pri_wdata_i = 8'(p); evt_i = N'(q);
          tick();
          chk_req("R1_R2_R4", exp_vec(8'h80 | 8'(e), 8'(p), N'(q), 0));
          sw_clr_i = '1;
          tick();
        end

    // gate off: R3
    for (int e = 0; e < 32; e++)
      for (int q = 0; q < 32; q++) begin
        en_we_i = 1; en_wdata_i = 8'(e); evt_i = N'(q);
        tick();
        chk(!irq_o && vec_o == 0, "R3", {irq_o, vec_o}, 0);
        sw_clr_i = '1;
        tick();
      end

    // R10 set beats clear, R11 software clear
    evt_i[1] = 1; sw_clr_i[1] = 1;
    tick();
    chk(pend_o == 5'b00010, "R10", pend_o, 5'b00010);
    sw_clr_i[1] = 1;
    tick();
    chk(pend_o == 0, "R11", pend_o, 0);

    // nesting: tmr1 high, others low
    en_we_i = 1; en_wdata_i = 8'h9F; pri_we_i = 1; pri_wdata_i = 8'h08;
    tick();
    evt_i[4] = 1;
    tick();
    chk_req("R2", 16'h0023);
    ack_i = 1;
    tick();
    chk(act_o == 2'b01, "R5", act_o, 2'b01);
    chk(pend_o[4], "R9", pend_o, 5'b10000);
    chk_req("R7", 0);
    evt_i[0] = 1;
    tick();
    chk_req("R7", 0);
    evt_i[3] = 1;
    tick();
    chk_req("R7", 16'h001B);
    ack_i = 1;
    tick();
    chk(act_o == 2'b11, "R5", act_o, 2'b11);
    chk(pend_o == 5'b10001, "R9", pend_o, 5'b10001);
    chk_req("R6", 0);
    evt_i[3] = 1;
    tick();
    chk_req("R6", 0);
    sw_clr_i[3] = 1;
    tick();
    reti_i = 1;
    tick();
    chk(act_o == 2'b01, "R8", act_o, 2'b01);
    chk_req("R7", 0);
    reti_i = 1;
    tick();
    chk(act_o == 2'b00, "R8", act_o, 0);
    chk_req("R4", 16'h0003);
    ack_i = 1;
    tick();
    chk(act_o == 2'b01 && pend_o == 5'b10000, "R9", {act_o, pend_o}, {2'b01, 5'b10000});
    reti_i = 1;
    tick();
    chk_req("R9", 16'h0023);
    sw_clr_i[4] = 1;
    tick();
    chk_req("R11", 0);

    finish_run();
  end
endmodule